// File: doc/BRIEF.md
# Cell FIFO Transmit Port

This block is the read side of a cell-oriented FIFO that feeds a cell-level transmit interface. It pulls 9-bit words from a show-ahead FIFO and sends them to the far side in cells of a fixed word count. Each word goes out whole on a 9-bit bus or as two 4-bit nibbles on the low data lines. In nibble mode the ninth bit rides on the top line for both halves of the word.

The port works in one of two roles. As master it paces the transfer itself and marks each transfer cycle with an active-low enable output. As slave it waits for an active-low enable input from the far side and moves on by one transfer per sampled enable. Whichever role is chosen, the port starts a cell only when the FIFO holds a whole cell and the far side signals that it can accept one. It flags the first transfer of the cell and then sends the whole cell without stopping to check again. The bus width and the role are captured when a cell starts and stay fixed until that cell has been sent.

Top module: `cell_fifo_txport`

## Requirements
- R1: In word mode (`bus_wide`=1) each transfer drives the complete FIFO word on `dout[8:0]`, one word per transfer.
- R2: In nibble mode (`bus_wide`=0) each word takes two transfers: first `dout[3:0]` = word bits 3:0, then `dout[3:0]` = word bits 7:4. `dout[6:4]` is 0 and `dout[8]` is word bit 8 on both transfers.
- R3: In nibble mode `dout[7]` is 1 on every master transfer and 0 on every slave transfer. After a master nibble cell ends it returns to 0.
- R4: `soc` is high for exactly one cycle, aligned with the first transfer of a cell, and low for every other transfer.
- R5: As master, `en_n_out` is 0 exactly in the cycles whose outputs carry a transfer. All transfers of a cell come in consecutive cycles, and two back-to-back cells are separated by exactly one cycle with `en_n_out`=1.
- R6: As slave, each rising edge at which `en_n_in`=0 (while a cell is in progress) presents the next transfer. Without it `dout` holds, `soc` is 0, and `en_n_out` stays 1.
- R7: A cell starts only at an edge where `fifo_cell_rdy`=1 (at least 53 words stored) and `cell_avail`=1. Otherwise no word is popped and no transfer happens.
- R8: Once started, a cell of 53 words is sent to the end even if `cell_avail` falls.
- R9: `bus_wide` and `role_slave` are sampled at cell start. Changing them during a cell does not alter that cell.
- R10: `fifo_pop` pulses once per word, together with the word's last transfer, so one cell removes exactly 53 words in order.
- R11: A synchronous active-high `rst` clears the sequencer. During and after reset `en_n_out`=1, `soc`=0, `dout`=0 and `fifo_pop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wide | input | 1 | 1: 9-bit word transfers, 0: nibble transfers |
| role_slave | input | 1 | 1: slave role (enable is an input), 0: master role |
| fifo_word | input | 9 | Head word of the show-ahead FIFO |
| fifo_cell_rdy | input | 1 | FIFO holds at least one complete cell |
| fifo_pop | output | 1 | Removes the head word at this edge |
| cell_avail | input | 1 | Far side can accept a cell |
| en_n_in | input | 1 | Slave-role transfer enable, active low |
| en_n_out | output | 1 | Master-role transfer enable, active low |
| soc | output | 1 | First transfer of a cell |
| dout | output | 9 | Transfer data lines |

## Verification
Cells are sent in all four combinations of role and width. A 9-bit word and the two nibbles taken from it are each compared against a scoreboard, which separates a correct nibble split from swapped or unpadded halves and also shows whether the strobe line follows the role. The slave bench mixes consecutive enables with gaps, so that holding differs from advancing. Other cases keep the start from happening: a full cell with the far side not ready, and 52 words with the far side ready. Further cases drop readiness or flip the mode inputs during a cell, and run two cells back to back. Together these show that the start is taken per whole cell and that the mode is latched at that point.

// File: rtl/cellport_pkg.sv
package cellport_pkg;
   typedef enum logic { ROLE_MASTER = 1'b0, ROLE_SLAVE = 1'b1 } role_e;
   typedef enum logic { BUS_NIBBLE = 1'b0, BUS_WORD = 1'b1 } width_e;
endpackage

// File: rtl/cellport_seq.sv
module cellport_seq
   import cellport_pkg::*;
#(
   parameter int CELL_WORDS = 53,
   parameter int NPW        = 2,
   localparam int CNT_W     = $clog2(CELL_WORDS),
   localparam int PH_W      = (NPW > 1) ? $clog2(NPW) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bus_wide,
   input  logic            role_slave,
   input  logic            fifo_cell_rdy,
   input  logic            cell_avail,
   input  logic            en_n_in,
   output logic            busy,
   output width_e          wide_l,
   output role_e           slave_l,
   output logic [PH_W-1:0] phase,
   output logic            adv,
   output logic            first,
   output logic            pop
);
   logic [CNT_W-1:0] wcnt;
   logic             start, last_ph, last_w;

   assign start   = !busy && fifo_cell_rdy && cell_avail;
   assign adv     = busy && ((slave_l == ROLE_MASTER) || !en_n_in);
   assign last_ph = (wide_l == BUS_WORD) || (phase == PH_W'(NPW - 1));
   assign last_w  = (wcnt == CNT_W'(CELL_WORDS - 1));
   assign first   = (wcnt == '0) && (phase == '0);
   assign pop     = adv && last_ph;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         wcnt    <= '0;
         phase   <= '0;
         wide_l  <= BUS_NIBBLE;
         slave_l <= ROLE_MASTER;
      end else if (start) begin
         busy    <= 1'b1;
         wcnt    <= '0;
         phase   <= '0;
         wide_l  <= width_e'(bus_wide);
         slave_l <= role_e'(role_slave);
      end else if (adv) begin
         if (last_ph) begin
            phase <= '0;
            if (last_w) begin
               wcnt <= '0;
               busy <= 1'b0;
            end else begin
               wcnt <= wcnt + 1'b1;
            end
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   // R7
   start_gate_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(fifo_cell_rdy && cell_avail));
   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ($stable(wide_l) && $stable(slave_l)));
   // R8
   cell_run_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !(pop && last_w)) |=> busy);
   // R10
   wcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      wcnt <= CNT_W'(CELL_WORDS - 1));
endmodule

// File: rtl/cellport_fmt.sv
module cellport_fmt
   import cellport_pkg::*;
#(
   parameter int WORD_W = 9,
   parameter int NIB_W  = 4,
   parameter int NPW    = 2,
   parameter int PH_W   = 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [PH_W-1:0]   phase,
   input  width_e            wide,
   input  role_e             slave,
   output logic [WORD_W-1:0] vec
);
   logic [NIB_W-1:0] nib [NPW];

   for (genvar g = 0; g < NPW; g++) begin : g_slice
      assign nib[g] = word[g*NIB_W +: NIB_W];
   end

   always_comb begin
      vec = '0;
      if (wide == BUS_WORD) begin
         vec = word;
      end else begin
         vec[NIB_W-1:0]  = nib[phase];
         vec[WORD_W-2]   = (slave == ROLE_MASTER);
         vec[WORD_W-1]   = word[WORD_W-1];
      end
   end
endmodule

// File: rtl/cell_fifo_txport.sv
module cell_fifo_txport
   import cellport_pkg::*;
#(
   parameter int WORD_W     = 9,
   parameter int NIB_W      = 4,
   parameter int CELL_WORDS = 53
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wide,
   input  logic              role_slave,
   input  logic [WORD_W-1:0] fifo_word,
   input  logic              fifo_cell_rdy,
   output logic              fifo_pop,
   input  logic              cell_avail,
   input  logic              en_n_in,
   output logic              en_n_out,
   output logic              soc,
   output logic [WORD_W-1:0] dout
);
   localparam int NPW  = (WORD_W - 1) / NIB_W;
   localparam int PH_W = (NPW > 1) ? $clog2(NPW) : 1;

   if (WORD_W < NIB_W + 2) begin : g_bad_width
      $error("WORD_W too narrow for nibble lane, strobe and ninth bit");
   end
   if (((WORD_W - 1) % NIB_W) != 0) begin : g_bad_split
      $error("WORD_W-1 must be a multiple of NIB_W");
   end
   if (CELL_WORDS < 2) begin : g_bad_cell
      $error("CELL_WORDS must be at least 2");
   end

   logic              busy, adv, first;
   width_e            wide_l;
   role_e             slave_l;
   logic [PH_W-1:0]   phase;
   logic [WORD_W-1:0] fmt_vec;

   cellport_seq #(.CELL_WORDS(CELL_WORDS), .NPW(NPW)) u_seq (
      .clk(clk), .rst(rst), .bus_wide(bus_wide), .role_slave(role_slave),
      .fifo_cell_rdy(fifo_cell_rdy), .cell_avail(cell_avail), .en_n_in(en_n_in),
      .busy(busy), .wide_l(wide_l), .slave_l(slave_l), .phase(phase),
      .adv(adv), .first(first), .pop(fifo_pop)
   );

   cellport_fmt #(.WORD_W(WORD_W), .NIB_W(NIB_W), .NPW(NPW), .PH_W(PH_W)) u_fmt (
      .word(fifo_word), .phase(phase), .wide(wide_l), .slave(slave_l), .vec(fmt_vec)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dout     <= '0;
         soc      <= 1'b0;
         en_n_out <= 1'b1;
      end else begin
         en_n_out <= !(adv && (slave_l == ROLE_MASTER));
         soc      <= adv && first;
         if (adv) begin
            dout <= fmt_vec;
         end else if ((wide_l == BUS_NIBBLE) && (slave_l == ROLE_MASTER)) begin
            dout[WORD_W-2] <= 1'b0;
         end
      end
   end

   // R4
   soc_single_chk: assert property (@(posedge clk) disable iff (rst)
      soc |=> !soc);
   // R5
   soc_master_en_chk: assert property (@(posedge clk) disable iff (rst)
      (soc && (slave_l == ROLE_MASTER)) |-> !en_n_out);
   // R6
   slave_en_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ((slave_l == ROLE_SLAVE) && $past(slave_l == ROLE_SLAVE)) |-> en_n_out);
   // R2
   nibble_pad_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_n_out && (wide_l == BUS_NIBBLE)) |-> (dout[WORD_W-3:NIB_W] == '0));
   // R3
   strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && (wide_l == BUS_NIBBLE) && (slave_l == ROLE_MASTER))
      |-> (dout[WORD_W-2] == !en_n_out));
endmodule

// File: tb/test_cell_fifo_txport.sv
module test_cell_fifo_txport;
   localparam int CLK_PERIOD = 10;
   localparam int CELL       = 53;

   logic       clk = 1'b0, rst = 1'b1;
   logic       bus_wide = 1'b1, role_slave = 1'b0;
   logic [8:0] fifo_word = '0;
   logic       fifo_cell_rdy = 1'b0, cell_avail = 1'b0, en_n_in = 1'b1;
   logic       fifo_pop, en_n_out, soc;
   logic [8:0] dout;

   int         n_run = 0, n_fail = 0, cyc = 0;
   logic [9:0] exp_q[$];
   logic [8:0] fq[$];
   logic       pend = 1'b0, cur_slave = 1'b0, cur_wide = 1'b1, slv_fire = 1'b0;
   logic [8:0] prev_d = '0;

   cell_fifo_txport i_cell_fifo_txport (
      .clk(clk), .rst(rst), .bus_wide(bus_wide), .role_slave(role_slave),
      .fifo_word(fifo_word), .fifo_cell_rdy(fifo_cell_rdy), .fifo_pop(fifo_pop),
      .cell_avail(cell_avail), .en_n_in(en_n_in), .en_n_out(en_n_out),
      .soc(soc), .dout(dout)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic void refresh();
      fifo_word     = (fq.size() != 0) ? fq[0] : 9'h0;
      fifo_cell_rdy = (fq.size() >= CELL);
   endfunction

   // FIFO model: pop request sampled mid-cycle, applied just after the edge
   always @(negedge clk) begin
      #2;
      pend = fifo_pop;
   end
   always @(posedge clk) begin
      #1;
      if (pend && !rst) begin
         if (fq.size() == 0) chk(1'b0, "R10", "pop from empty FIFO", 1, 0);
         else void'(fq.pop_front());
      end
      refresh();
   end

   task automatic compare_item();
      logic [9:0] item;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R10", "transfer with nothing expected", {soc, dout}, 0);
      end else begin
         item = exp_q.pop_front();
         chk(dout == item[8:0], cur_wide ? "R1" : "R2", "dout", dout, item[8:0]);
         chk(soc == item[9], "R4", "soc", soc, item[9]);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (!cur_slave) begin
            if (!en_n_out) compare_item();
            else if (soc) chk(1'b0, "R4", "soc without transfer", 1, 0);
         end else begin
            if (slv_fire) compare_item();
            else begin
               chk(dout == prev_d, "R6", "dout hold", dout, prev_d);
               chk(!soc, "R6", "soc while holding", soc, 0);
            end
            chk(en_n_out, "R6", "en_n_out in slave role", en_n_out, 1);
         end
      end
      prev_d = dout;
   end

   task automatic load(input int n, input int seed, input int base,
                       input bit wide, input bit slave);
      for (int i = 0; i < n; i++) begin
         logic [8:0] w;
         w = 9'((seed * 71 + (base + i) * 29 + 5) % 512);
         fq.push_back(w);
         if (wide) begin
            exp_q.push_back({(base + i) == 0, w});
         end else begin
            exp_q.push_back({(base + i) == 0, w[8], ~slave, 3'b000, w[3:0]});
            exp_q.push_back({1'b0, w[8], ~slave, 3'b000, w[7:4]});
         end
      end
      refresh();
   endtask

   // mode 0: plain, 1: drop cell_avail after start (R8), 2: flip modes (R9)
   task automatic run_master(input int items, input int mode, input string req);
      int span = 0;
      int guard = 0;
      bit started = 0;
      while (exp_q.size() != 0 && guard < 3000) begin
         @(negedge clk);
         #2;
         guard++;
         if (!en_n_out) started = 1;
         if (started) begin
            span++;
            if (mode == 1) cell_avail = 1'b0;
            if (mode == 2) begin
               bus_wide   = ~bus_wide;
               role_slave = 1'b1;
            end
         end
      end
      chk(span == items, req, "transfer span in cycles", span, items);
   endtask

   task automatic run_slave(input int items);
      @(negedge clk);
      #1;
      for (int i = 0; i < items; i++) begin
         en_n_in  = 1'b0;
         slv_fire = 1'b1;
         @(negedge clk);
         #1;
         if (i % 3 == 1) begin
            en_n_in  = 1'b1;
            slv_fire = 1'b0;
            @(negedge clk);
            #1;
         end
      end
      en_n_in  = 1'b1;
      slv_fire = 1'b0;
      chk(exp_q.size() == 0, "R6", "slave items left", exp_q.size(), 0);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog", "run did not finish", cyc, 100000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: state held in reset
      chk(en_n_out == 1'b1, "R11", "en_n_out in reset", en_n_out, 1);
      chk(soc == 1'b0, "R11", "soc in reset", soc, 0);
      chk(dout == 9'h0, "R11", "dout in reset", dout, 0);
      chk(fifo_pop == 1'b0, "R11", "fifo_pop in reset", fifo_pop, 0);
      #1 rst = 1'b0;

      // R1, R5, R10: master word cell
      cur_slave = 0; cur_wide = 1; bus_wide = 1; role_slave = 0;
      load(CELL, 1, 0, 1, 0);
      cell_avail = 1'b1;
      run_master(CELL, 0, "R5");
      cell_avail = 1'b0;
      chk(fq.size() == 0, "R10", "words left after word cell", fq.size(), 0);

      // R2, R3: master nibble cell
      @(negedge clk); #1;
      cur_wide = 0; bus_wide = 0;
      load(CELL, 2, 0, 0, 0);
      cell_avail = 1'b1;
      run_master(2 * CELL, 0, "R2");
      cell_avail = 1'b0;
      repeat (2) @(negedge clk);
      chk(dout[7] == 1'b0, "R3", "strobe after nibble cell", dout[7], 0);
      chk(fq.size() == 0, "R10", "words left after nibble cell", fq.size(), 0);

      // R7: full cell but far side not ready
      #1;
      cur_wide = 1; bus_wide = 1;
      load(CELL, 3, 0, 1, 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(en_n_out == 1'b1, "R7", "transfer without cell_avail", en_n_out, 1);
      end
      chk(fq.size() == CELL, "R7", "pops without cell_avail", fq.size(), CELL);
      // R8: cell_avail falls after the start
      #1 cell_avail = 1'b1;
      run_master(CELL, 1, "R8");
      cell_avail = 1'b0;

      // R7: ready far side but only 52 words stored
      @(negedge clk); #1;
      cur_wide = 0; bus_wide = 0;
      load(CELL - 1, 4, 0, 0, 0);
      cell_avail = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(en_n_out == 1'b1, "R7", "transfer with partial cell", en_n_out, 1);
      end
      chk(fq.size() == CELL - 1, "R7", "pops with partial cell", fq.size(), CELL - 1);
      #1 load(1, 4, CELL - 1, 0, 0);
      run_master(2 * CELL, 0, "R7");
      cell_avail = 1'b0;

      // R6: slave nibble cell with mixed enable gaps
      @(negedge clk); #1;
      cur_slave = 1; role_slave = 1; cur_wide = 0; bus_wide = 0;
      load(CELL, 5, 0, 0, 1);
      cell_avail = 1'b1;
      run_slave(2 * CELL);
      cell_avail = 1'b0;
      chk(fq.size() == 0, "R10", "words left after slave nibble cell", fq.size(), 0);

      // R6, R1: slave word cell
      @(negedge clk); #1;
      cur_wide = 1; bus_wide = 1;
      load(CELL, 6, 0, 1, 1);
      cell_avail = 1'b1;
      run_slave(CELL);
      cell_avail = 1'b0;

      // R9: mode inputs flipped during a master word cell
      @(negedge clk); #1;
      cur_slave = 0; role_slave = 0; cur_wide = 1; bus_wide = 1;
      load(CELL, 7, 0, 1, 0);
      cell_avail = 1'b1;
      run_master(CELL, 2, "R9");
      cell_avail = 1'b0;
      role_slave = 0; bus_wide = 1;

      // R5: two cells back to back, one idle cycle between
      @(negedge clk); #1;
      load(CELL, 8, 0, 1, 0);
      load(CELL, 9, 0, 1, 0);
      cell_avail = 1'b1;
      run_master(2 * CELL + 1, 0, "R5");
      cell_avail = 1'b0;
      chk(fq.size() == 0, "R10", "words left after two cells", fq.size(), 0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule